// File: doc/BRIEF.md
# Byte-Programmable Watchdog Countdown Timer

This block is a watchdog that is programmed through three byte-wide configuration registers reached over a simple indexed write/read port. The count register does several jobs at once. A write of a nonzero value arms the timer or restarts it, and also records that value as the reload value. A write of zero stops the timer. A read returns the number of time units still left. Once armed, the count drops by one on each time unit. A unit is either a "second" or a "minute", each built from the system clock by a prescaler.

When the count reaches zero it stays there. The block then sets a sticky expired flag in the status register. If the control register allows it, the block also drives an active-low reset pulse of fixed length. Two activity strobes, keyboard and mouse, can each be allowed through a status bit. An allowed strobe reloads the last programmed value into the running timer.

Top module: `wdt_byte_timer`

## Requirements
- R1: A write of a nonzero value V to the count register (index 0xF6) sets the count to V in the next cycle. From then on, reading index 0xF6 returns the remaining count.
- R2: A write of 0 to the count register stops the timer. The count stays at 0 and no expiry follows.
- R3: When control bit 3 is 0 (seconds mode), a running count decrements once every TICK_DIV clock cycles, counted from the write that armed it.
- R4: When control bit 3 is 1 (minutes mode), a running count decrements once every TICK_DIV*MIN_MULT clock cycles.
- R5: When the count steps from 1 to 0, it holds at 0 and status bit 4 (expired flag, read at index 0xF7) becomes 1 in the same cycle.
- R6: If control bit 1 (index 0xF5) is 1 at expiry, `wdt_rst_n` goes low in the cycle after the expiry edge and stays low for PULSE_LEN cycles. If control bit 1 is 0, `wdt_rst_n` stays high.
- R7: A status write with bit 4 = 0 clears the expired flag. A status write with bit 4 = 1 leaves the flag unchanged.
- R8: When status bit 7 is 1, a `kbd_evt` strobe on a running timer reloads the last programmed nonzero value. When status bit 7 is 0, the strobe is ignored.
- R9: When status bit 6 is 1, a `mouse_evt` strobe on a running timer reloads the last programmed nonzero value.
- R10: Activity strobes never revive a count of 0. Only a new nonzero write to the count register rearms the timer.
- R11: After reset the count, control and status all read 0 and `wdt_rst_n` is high. Any index other than 0xF5, 0xF6 and 0xF7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Register index for both read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| kbd_evt | input | 1 | Keyboard activity strobe |
| mouse_evt | input | 1 | Mouse activity strobe |
| wdt_rst_n | output | 1 | Active-low reset pulse driven on expiry |

## Verification
The assertions watch every cycle for the following:
- a count write landing with the written value;
- a zero count staying dead without a fresh write;
- every other count change being a single-step decrement;
- the flag rising only on a 1-to-0 step;
- the reset pulse starting only at an enabled expiry;
- the flag falling only on a clearing status write.

Only the bench scenarios can show the absolute decrement period in each unit mode, the exact length of the pulse, and the fact that a disabled strobe leaves the count alone. All three need cycle counting against a programmed value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTRL_PULSE_BIT = 1;
  localparam int unsigned CTRL_MIN_BIT   = 3;
  localparam int unsigned ST_KBD_BIT     = 7;
  localparam int unsigned ST_MSE_BIT     = 6;
  localparam int unsigned ST_FLAG_BIT    = 4;

  // clock cycles in one time unit for the selected mode
  function automatic int unsigned unit_clocks(input logic minute,
                                              input int unsigned div,
                                              input int unsigned mult);
    return minute ? div * mult : div;
  endfunction

  // assemble the status byte from its three live bits
  function automatic logic [7:0] status_byte(input logic kbd, input logic mse,
                                             input logic flag);
    logic [7:0] b;
    b = '0;
    b[ST_KBD_BIT]  = kbd;
    b[ST_MSE_BIT]  = mse;
    b[ST_FLAG_BIT] = flag;
    return b;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_DIV = 1000,
  parameter int unsigned MIN_MULT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic minute,
  output logic tick
);
  import wdt_pkg::*;
  localparam int unsigned LIM_MAX = TICK_DIV * MIN_MULT;
  localparam int unsigned PW      = $clog2(LIM_MAX + 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  assign lim  = PW'(unit_clocks(minute, TICK_DIV, MIN_MULT));
  assign tick = run && !restart && (cnt_q >= lim - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || restart) cnt_q <= '0;
    else if (tick)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          stop,
  input  logic [CW-1:0] load_val,
  input  logic          kick,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          kick_eff,
  output logic          expire
);
  logic [CW-1:0] cnt_q, reload_q;
  logic          live;

  assign live     = (cnt_q != '0);
  assign kick_eff = kick && live && !load && !stop;
  assign expire   = tick && (cnt_q == CW'(1)) && !load && !stop && !kick_eff;
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt_q    <= load_val;
      reload_q <= load_val;
    end else if (stop) begin
      cnt_q    <= '0;
    end else if (kick_eff) begin
      cnt_q    <= reload_q;
    end else if (tick && live) begin
      cnt_q    <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_n
);
  localparam int unsigned LW = $clog2(PULSE_LEN + 1);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= LW'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - LW'(1);
  end

  assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wdt_byte_timer.sv
module wdt_byte_timer #(
  parameter int unsigned TICK_DIV  = 1000,
  parameter int unsigned MIN_MULT  = 60,
  parameter int unsigned PULSE_LEN = 16,
  parameter logic [7:0]  ADDR_CTRL = 8'hF5,
  parameter logic [7:0]  ADDR_TMO  = 8'hF6,
  parameter logic [7:0]  ADDR_ST   = 8'hF7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       wdt_rst_n
);
  import wdt_pkg::*;
  localparam int unsigned CW = 8;

  logic [7:0]    ctrl_q;
  logic          st_kbd_q, st_mse_q, flag_q;
  logic          tmo_wr, ctrl_wr, st_wr;
  logic          load, stop, kick, kick_eff, tick, expire, pulse_en, minute;
  logic [CW-1:0] count;

  assign tmo_wr   = cfg_we && (cfg_addr == ADDR_TMO);
  assign ctrl_wr  = cfg_we && (cfg_addr == ADDR_CTRL);
  assign st_wr    = cfg_we && (cfg_addr == ADDR_ST);
  assign load     = tmo_wr && (cfg_wdata != '0);
  assign stop     = tmo_wr && (cfg_wdata == '0);
  assign kick     = (kbd_evt && st_kbd_q) || (mouse_evt && st_mse_q);
  assign pulse_en = ctrl_q[CTRL_PULSE_BIT];
  assign minute   = ctrl_q[CTRL_MIN_BIT];

  wdt_prescaler #(.TICK_DIV(TICK_DIV), .MIN_MULT(MIN_MULT)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(count != '0),
    .restart(load || stop || kick_eff), .minute(minute), .tick(tick));

  wdt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
    .load_val(cfg_wdata), .kick(kick), .tick(tick),
    .count(count), .kick_eff(kick_eff), .expire(expire));

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire && pulse_en), .pulse_n(wdt_rst_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      st_kbd_q <= 1'b0;
      st_mse_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= cfg_wdata;
      if (st_wr) begin
        st_kbd_q <= cfg_wdata[ST_KBD_BIT];
        st_mse_q <= cfg_wdata[ST_MSE_BIT];
      end
      if (expire)                               flag_q <= 1'b1;
      else if (st_wr && !cfg_wdata[ST_FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    if (cfg_addr == ADDR_TMO)       cfg_rdata = count;
    else if (cfg_addr == ADDR_CTRL) cfg_rdata = ctrl_q;
    else if (cfg_addr == ADDR_ST)   cfg_rdata = status_byte(st_kbd_q, st_mse_q, flag_q);
    else                            cfg_rdata = '0;
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter logic [7:0] ADDR_TMO = 8'hF6,
  parameter logic [7:0] ADDR_ST  = 8'hF7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       wdt_rst_n,
  input logic [7:0] count,
  input logic       kick_eff,
  input logic       expire,
  input logic       pulse_en,
  input logic       flag_q
);
  logic tmo_w;
  assign tmo_w = cfg_we && (cfg_addr == ADDR_TMO);

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_w && (cfg_wdata != 8'd0) |=> count == $past(cfg_wdata));

  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_w && (cfg_wdata == 8'd0) |=> count == 8'd0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) && !$past(tmo_w) && !$past(kick_eff) |-> count == $past(count) - 8'd1);

  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(count) == 8'd1) && (count == 8'd0));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_n) |-> $past(expire) && $past(pulse_en));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(cfg_we && (cfg_addr == ADDR_ST) && !cfg_wdata[4]));

  p_dead_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 8'd0) && !tmo_w |=> count == 8'd0);
endmodule

bind wdt_byte_timer wdt_checker #(.ADDR_TMO(ADDR_TMO), .ADDR_ST(ADDR_ST)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .wdt_rst_n(wdt_rst_n), .count(count),
  .kick_eff(kick_eff), .expire(expire), .pulse_en(pulse_en), .flag_q(flag_q));

// File: tb/sim_wdt_byte_timer.sv
module sim_wdt_byte_timer;
  localparam int DIV = 4;
  localparam int MUL = 60;
  localparam int PLEN = 3;
  localparam logic [7:0] A_CTRL = 8'hF5, A_TMO = 8'hF6, A_ST = 8'hF7;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic wdt_rst_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_byte_timer #(.TICK_DIV(DIV), .MIN_MULT(MUL), .PULSE_LEN(PLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .kbd_evt(kbd_evt),
    .mouse_evt(mouse_evt), .wdt_rst_n(wdt_rst_n));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    cfg_addr = a; #1; v = cfg_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(bit kb, bit ms);
    kbd_evt = kb; mouse_evt = ms;
    @(negedge clk);
    kbd_evt = 1'b0; mouse_evt = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    rd(A_TMO, v);  chk("R11", "count after reset", v, 0);
    rd(A_CTRL, v); chk("R11", "control after reset", v, 0);
    rd(A_ST, v);   chk("R11", "status after reset", v, 0);
    chk("R11", "wdt_rst_n after reset", wdt_rst_n, 1);
    rd(8'h10, v);  chk("R11", "unused index", v, 0);
  endtask

  task automatic t_seconds();
    int v;
    wr(A_CTRL, 8'h00);
    wr(A_TMO, 8'd3);
    rd(A_TMO, v); chk("R1", "count after load", v, 3);
    wait_cyc(DIV - 1); rd(A_TMO, v); chk("R3", "before first unit", v, 3);
    wait_cyc(1);       rd(A_TMO, v); chk("R3", "after first unit", v, 2);
    wait_cyc(2*DIV - 1); rd(A_TMO, v); chk("R3", "one unit left", v, 1);
    rd(A_ST, v); chk("R5", "flag before expiry", (v >> 4) & 1, 0);
    wait_cyc(1); rd(A_TMO, v); chk("R5", "count at expiry", v, 0);
    rd(A_ST, v); chk("R5", "flag at expiry", (v >> 4) & 1, 1);
    chk("R6", "no pulse when disabled", wdt_rst_n, 1);
    wait_cyc(8); rd(A_TMO, v); chk("R5", "count holds 0", v, 0);
  endtask

  task automatic t_flag();
    int v;
    wr(A_ST, 8'h10); rd(A_ST, v); chk("R7", "write 1 keeps flag", (v >> 4) & 1, 1);
    wr(A_ST, 8'h00); rd(A_ST, v); chk("R7", "write 0 clears flag", (v >> 4) & 1, 0);
  endtask

  task automatic t_pulse();
    wr(A_CTRL, 8'h02);
    wr(A_TMO, 8'd1);
    wait_cyc(DIV - 1); chk("R6", "high before expiry", wdt_rst_n, 1);
    wait_cyc(1);       chk("R6", "low after expiry", wdt_rst_n, 0);
    wait_cyc(PLEN - 1); chk("R6", "low at last pulse cycle", wdt_rst_n, 0);
    wait_cyc(1);       chk("R6", "high after pulse", wdt_rst_n, 1);
    wr(A_ST, 8'h00);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_stop();
    int v;
    wr(A_TMO, 8'd5);
    wait_cyc(6);
    wr(A_TMO, 8'd0);
    rd(A_TMO, v); chk("R2", "count after stop", v, 0);
    wait_cyc(40);
    rd(A_TMO, v); chk("R2", "stays stopped", v, 0);
    rd(A_ST, v);  chk("R2", "no expiry after stop", (v >> 4) & 1, 0);
  endtask

  task automatic t_minute();
    int v;
    wr(A_CTRL, 8'h08);
    wr(A_TMO, 8'd2);
    wait_cyc(DIV*MUL - 1); rd(A_TMO, v); chk("R4", "before minute unit", v, 2);
    wait_cyc(1);           rd(A_TMO, v); chk("R4", "after minute unit", v, 1);
    wr(A_TMO, 8'd0);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_kick();
    int v;
    wr(A_ST, 8'h80);
    wr(A_TMO, 8'd4);
    wait_cyc(2*DIV + 1); rd(A_TMO, v); chk("R8", "count before kick", v, 2);
    strobe(1, 0); rd(A_TMO, v); chk("R8", "keyboard kick reloads", v, 4);
    wr(A_ST, 8'h00);
    wait_cyc(DIV - 1);   rd(A_TMO, v); chk("R8", "count before ignored strobe", v, 3);
    strobe(1, 0); rd(A_TMO, v); chk("R8", "disabled keyboard ignored", v, 3);
    wr(A_ST, 8'h40);
    strobe(0, 1); rd(A_TMO, v); chk("R9", "mouse kick reloads", v, 4);
  endtask

  task automatic t_rearm();
    int v;
    wr(A_ST, 8'hC0);
    wr(A_TMO, 8'd0);
    strobe(1, 1); rd(A_TMO, v); chk("R10", "strobe cannot revive", v, 0);
    wr(A_TMO, 8'd2); rd(A_TMO, v); chk("R10", "write rearms", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_flag();
    t_pulse();
    t_stop();
    t_minute();
    t_kick();
    t_rearm();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule